// File: doc/BRIEF.md
# Configurable Event Channel Router

This block routes event sources to a set of event channels. Each channel picks one of up to 127 generator lines, passes the picked level through a path of its own choosing, and drives one channel output. On the two clocked paths the output is a one-cycle pulse made by an edge detector. The synchronous path samples the line directly. The resynchronizing path first passes it through two flops. On the asynchronous path the output is a plain combinational copy of the line's level.

Software reaches every channel through one 32-bit configuration word with byte enables. A channel index held in that word chooses whose settings a write changes and whose settings a read returns. A write-only trigger bit in the same word can inject a single event pulse on the channel named in that write. The reset input is asserted asynchronously and released in step with the clock inside the block.

Top module: `evt_router`

## Requirements
- R1: The index field is word bits 3:0 and is written when byte enable 0 is set. The read word always shows the stored index in bits 3:0, the indexed channel's generator select in bits 22:16, its path code in bits 25:24 and its edge code in bits 27:26. Every other bit reads 0.
- R2: A write changes only the channel named by the index. If byte enable 0 is set in the same write, the new index applies. Byte enable 2 writes the generator select. Byte enable 3 writes the path and edge codes. Settings take effect from the next cycle.
- R3: Generator select k in the range 1 to 0x53 picks line gen_i[k-1]. Select 0, and any select above 0x53, picks no line, so the channel never produces a generator-driven event.
- R4: With path code 0 (synchronous), a change of the picked line that is present at clock edge n shows up as a pulse in the cycle that follows edge n.
- R5: Edge code 0 gives no generator event. Edge code 1 pulses on rising transitions, 2 pulses on falling transitions and 3 pulses on both. Each detected transition gives a pulse exactly one cycle long.
- R6: With path code 1 (resynchronizing), a change present at edge n shows up as a pulse in the cycle that follows edge n+2.
- R7: With path code 2 (asynchronous), the channel output follows the picked line's level combinationally, without edge detection.
- R8: A write that sets both byte enables 0 and 1 with bit 8 at 1 gives one pulse, in the cycle after that write, on the channel named by bits 3:0 of the same write. On clocked paths the pulse is ORed with detected edges, whatever the edge code. On the asynchronous path it is ORed with the level. Bit 8 always reads 0.
- R9: A write with bit 8 at 0, or without both byte enables 0 and 1, injects no event.
- R10: Path code 3 is reserved. A channel with path code 3 drives no output at all, including software events.
- R11: Reset clears every index, select, path and edge field to 0 and drives all channel outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| gen_i | input | NUM_GEN | Event generator lines; line k-1 is generator select k |
| cfg_wr_i | input | 1 | Configuration write strobe for one cycle |
| cfg_be_i | input | 4 | Byte enables for the write word |
| cfg_wdata_i | input | 32 | Configuration write word |
| cfg_rdata_o | output | 32 | Configuration read word for the indexed channel |
| evt_o | output | NUM_CH | Channel event outputs |

## Verification
The assertions assume that a channel's path is changed only while its picked line is low. They also assume that the edge code is 0 whenever the asynchronous path is chosen. If a path switch happened with the line high, the switch could produce a legitimate one-off edge, and the edge-mode properties do not try to cover that. The stimulus follows the same rules: each random trial configures one clocked channel while all lines are held low, lets the lines settle low for several cycles before random traffic starts, and then parks the channel at select 0 with edge code 0. The asynchronous trial uses edge code 0 only.

// File: rtl/evr_pkg.sv
package evr_pkg;

  localparam int unsigned IDX_W   = 4;
  localparam int unsigned GSEL_W  = 7;
  localparam int unsigned SWEV_BIT = 8;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    edge_e              edge_mode;
    path_e              path;
    logic [GSEL_W-1:0]  gsel;
  } ch_cfg_t;

  function automatic logic edge_hit(edge_e m, logic cur, logic prev);
    case (m)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [3:0]             be_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output ch_cfg_t [NUM_CH-1:0]   cfg_o,
  output logic [NUM_CH-1:0]      swev_o
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             swev_ok;
  ch_cfg_t          rd_cfg;

  // index next state and enable
  always_comb begin
    idx_en = wr_i && be_i[0];
    idx_d  = idx_en ? wdata_i[IDX_W-1:0] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // software trigger requires both low lanes so index and trigger travel together
  assign swev_ok = wr_i && be_i[0] && be_i[1] && wdata_i[SWEV_BIT];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ch_cfg_t cfg_q, cfg_d;
    logic    cfg_en;

    always_comb begin
      cfg_en = wr_i && (idx_d == IDX_W'(ch)) && (be_i[2] || be_i[3]);
      cfg_d  = cfg_q;
      if (be_i[2]) begin
        cfg_d.gsel = wdata_i[16 +: GSEL_W];
      end
      if (be_i[3]) begin
        cfg_d.path      = path_e'(wdata_i[25:24]);
        cfg_d.edge_mode = edge_e'(wdata_i[27:26]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (cfg_en) begin
        cfg_q <= cfg_d;
      end
    end

    assign cfg_o[ch]  = cfg_q;
    assign swev_o[ch] = swev_ok && (wdata_i[IDX_W-1:0] == IDX_W'(ch));
  end

  // read word assembly for the indexed channel
  always_comb begin
    rd_cfg = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx_q == IDX_W'(c)) rd_cfg = cfg_o[c];
    end
    rdata_o                 = '0;
    rdata_o[IDX_W-1:0]      = idx_q;
    rdata_o[16 +: GSEL_W]   = rd_cfg.gsel;
    rdata_o[25:24]          = rd_cfg.path;
    rdata_o[27:26]          = rd_cfg.edge_mode;
  end

  // R1: a written index is what the next read shows
  p_idx_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && be_i[0]) |=> (rdata_o[IDX_W-1:0] == $past(wdata_i[IDX_W-1:0])));

  // R2: a written select is read back from the targeted channel
  p_gen_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && be_i[2] && (32'(idx_d) < NUM_CH)) |=>
      (rdata_o[16 +: GSEL_W] == $past(wdata_i[16 +: GSEL_W])));

  // R8: at most one channel is triggered per write
  p_sw_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(swev_o));

  // R8: a trigger always comes with its index being stored
  p_sw_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|swev_o) |=> (rdata_o[IDX_W-1:0] == $past(wdata_i[IDX_W-1:0])));

endmodule

// File: rtl/evr_channel.sv
module evr_channel
  import evr_pkg::*;
#(
  parameter int unsigned NUM_GEN = 127,
  parameter int unsigned MAX_SEL = 83
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GEN-1:0] gen_i,
  input  ch_cfg_t            cfg_i,
  input  logic               swev_i,
  output logic               evt_o
);

  localparam int unsigned LAST_SEL = (MAX_SEL < NUM_GEN) ? MAX_SEL : NUM_GEN;

  logic gen_lvl;
  logic sy1_q, sy2_q;
  logic prev_q;
  logic samp;
  logic clocked;
  logic det;
  logic evt_d, evt_q;

  // generator pick; reserved and zero selects pick nothing
  always_comb begin
    gen_lvl = 1'b0;
    for (int g = 1; g <= int'(LAST_SEL); g++) begin
      if (cfg_i.gsel == GSEL_W'(g)) gen_lvl = gen_i[g-1];
    end
  end

  // two-flop resynchronizer, free running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b0;
      sy2_q <= 1'b0;
    end else begin
      sy1_q <= gen_lvl;
      sy2_q <= sy1_q;
    end
  end

  always_comb begin
    clocked = (cfg_i.path == PATH_SYNC) || (cfg_i.path == PATH_RESYNC);
    samp    = (cfg_i.path == PATH_RESYNC) ? sy2_q : gen_lvl;
    det     = clocked && edge_hit(cfg_i.edge_mode, samp, prev_q);
    evt_d   = (cfg_i.path != PATH_RSVD) && (det || swev_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= samp;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = (cfg_i.path == PATH_ASYNC) ? (gen_lvl | evt_q) : evt_q;

  // R5: edge code 0 on a clocked path gives nothing without software
  p_edge_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clocked && cfg_i.edge_mode == EDGE_NONE && !swev_i) |=> !evt_q);

  // R5: rising-only cannot fire while the sampled level is low
  p_rise_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clocked && cfg_i.edge_mode == EDGE_RISE && !swev_i && !samp) |=> !evt_q);

  // R10: reserved path stays silent
  p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.path == PATH_RSVD) |=> !evt_q);

  // R8: an accepted trigger on a usable path yields a pulse
  p_sw_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swev_i && cfg_i.path != PATH_RSVD) |=> evt_q);

endmodule

// File: rtl/evt_router.sv
module evt_router
  import evr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned NUM_GEN = 127,
  parameter int unsigned MAX_SEL = 83
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GEN-1:0] gen_i,
  input  logic               cfg_wr_i,
  input  logic [3:0]         cfg_be_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  output logic [NUM_CH-1:0]  evt_o
);

  ch_cfg_t [NUM_CH-1:0] cfg;
  logic    [NUM_CH-1:0] swev;
  logic                 rst_s1_q, rst_s2_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  evr_cfg_regs #(
    .NUM_CH (NUM_CH)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .wr_i    (cfg_wr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg),
    .swev_o  (swev)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    evr_channel #(
      .NUM_GEN (NUM_GEN),
      .MAX_SEL (MAX_SEL)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_s2_q),
      .gen_i  (gen_i),
      .cfg_i  (cfg[ch]),
      .swev_i (swev[ch]),
      .evt_o  (evt_o[ch])
    );
  end

  // R11: while held in reset every output is low
  p_reset_quiet_r11: assert property (@(posedge clk)
    (!rst_s2_q) |-> (evt_o == '0));

endmodule

// File: tb/sim_evt_router.sv
module sim_evt_router;

  localparam int NCH = 16;
  localparam int NG  = 127;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NG-1:0]   gen;
  logic            cfg_wr;
  logic [3:0]      cfg_be;
  logic [31:0]     cfg_wd;
  logic [31:0]     cfg_rd;
  logic [NCH-1:0]  evt;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_router u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_i       (gen),
    .cfg_wr_i    (cfg_wr),
    .cfg_be_i    (cfg_be),
    .cfg_wdata_i (cfg_wd),
    .cfg_rdata_o (cfg_rd),
    .evt_o       (evt)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // called at posedge+1, returns at posedge+1 after the write edge
  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_be = be;
    cfg_wd = d;
    cfg_wr = 1'b1;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    cfg_be = 4'h0;
    cfg_wd = 32'h0;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [31:0] cw(int ch, int gsel, int path, int em);
    return (32'(em) << 26) | (32'(path) << 24) | (32'(gsel) << 16) | 32'(ch);
  endfunction

  function automatic logic det(int em, logic c, logic p);
    case (em)
      1: return c & ~p;
      2: return ~c & p;
      3: return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NG-1:0] rnd_gen();
    logic [127:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom()};
    return t[NG-1:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n  = 1'b0;
    gen    = '0;
    cfg_wr = 1'b0;
    cfg_be = 4'h0;
    cfg_wd = 32'h0;
    step(3);
    rst_n = 1'b1;
    step(5);

    // R11 reset state
    chk("R11 evt after reset", 32'(evt), 32'h0);
    chk("R11 rdata after reset", cfg_rd, 32'h0);

    // R1 index and readback layout
    wr(4'b0001, 32'h5);
    chk("R1 index readback", cfg_rd, 32'h5);
    wr(4'b1101, cw(3, 'h12, 1, 2));
    chk("R1 full readback ch3", cfg_rd, cw(3, 'h12, 1, 2));

    // R2 only the indexed channel changes; lane split
    wr(4'b0001, 32'h7);
    chk("R2 ch7 untouched", cfg_rd, 32'h7);
    wr(4'b0100, 32'h005a0000);
    chk("R2 lane2 select only", cfg_rd, 32'h005a0007);
    wr(4'b1000, cw(0, 0, 2, 0));
    chk("R2 lane3 path only", cfg_rd, 32'h025a0007);
    wr(4'b1101, cw(7, 0, 0, 0));
    chk("R2 ch7 cleared", cfg_rd, 32'h7);
    wr(4'b0001, 32'h3);
    chk("R2 ch3 kept", cfg_rd, cw(3, 'h12, 1, 2));

    // R8 software event and bit 8 readback
    wr(4'b0011, 32'h103);
    chk("R8 sw pulse ch3", 32'(evt), 32'h8);
    chk("R8 bit8 reads 0", cfg_rd, cw(3, 'h12, 1, 2));
    step(1);
    chk("R8 sw pulse one cycle", 32'(evt), 32'h0);

    // R9 ignored triggers
    wr(4'b0001, 32'h103);
    chk("R9 no lane1", 32'(evt), 32'h0);
    wr(4'b0010, 32'h100);
    chk("R9 no lane0", 32'(evt), 32'h0);
    wr(4'b0011, 32'h3);
    chk("R9 bit8 zero", 32'(evt), 32'h0);

    // R10 reserved path silences software events
    wr(4'b1101, cw(3, 0, 3, 0));
    wr(4'b0011, 32'h103);
    chk("R10 reserved path quiet", 32'(evt), 32'h0);
    wr(4'b1101, cw(3, 0, 0, 0));

    // R3 R4 R5 R6 random clocked trials
    for (int t = 0; t < 12; t++) begin
      int   ch, path, em, gs;
      logic v1, v2, v3, v4, e;
      ch   = int'($urandom() % 16);
      path = t % 2;
      em   = (t < 4) ? (t + 1) % 4 : int'($urandom() % 4);
      gs   = 1 + int'($urandom() % 83);
      gen  = '0;
      wr(4'b1101, cw(ch, gs, path, em));
      step(5);
      v1 = 0; v2 = 0; v3 = 0; v4 = 0;
      for (int n = 0; n < 60; n++) begin
        e = (path == 1) ? det(em, v3, v4) : det(em, v1, v2);
        if (path == 1) chk("R6 R5 resync edge", 32'(evt), 32'(e) << ch);
        else           chk("R4 R5 sync edge", 32'(evt), 32'(e) << ch);
        gen = rnd_gen();
        v4 = v3; v3 = v2; v2 = v1; v1 = gen[gs-1];
        step(1);
      end
      gen = '0;
      step(5);
      wr(4'b1101, cw(ch, 0, 0, 0));
    end

    // R3 zero and reserved selects never fire
    for (int k = 0; k < 3; k++) begin
      int gs;
      gs = (k == 0) ? 'h54 : (k == 1) ? 'h7f : 0;
      gen = '0;
      wr(4'b1101, cw(9, gs, 0, 3));
      for (int n = 0; n < 15; n++) begin
        gen = rnd_gen();
        step(1);
        chk("R3 no generator", 32'(evt), 32'h0);
      end
    end
    gen = '0;
    wr(4'b1101, cw(9, 0, 0, 0));

    // R7 asynchronous level follow
    begin
      int gs;
      gs = 1 + int'($urandom() % 83);
      wr(4'b1101, cw(12, gs, 2, 0));
      for (int n = 0; n < 20; n++) begin
        gen = rnd_gen();
        #1;
        chk("R7 async follows", 32'(evt), 32'(gen[gs-1]) << 12);
        step(1);
      end
      gen = '0;
      #1;
      chk("R7 async low", 32'(evt), 32'h0);
      step(1);
      wr(4'b0011, 32'h10c);
      chk("R8 sw on async", 32'(evt), 32'h1000);
      step(1);
      chk("R8 sw on async ends", 32'(evt), 32'h0);
    end

    // R11 asynchronous reset assertion
    gen = '1;
    #1;
    rst_n = 1'b0;
    #1;
    chk("R11 evt in reset", 32'(evt), 32'h0);
    chk("R11 rdata in reset", cfg_rd, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule